// File: doc/BRIEF.md
# Sector Burst Mover

This block copies one disk sector from a byte-wide USB receive FIFO to a 16-bit parallel disk data port with no per-byte help from the microcontroller. The microcontroller pulses `start_i`, which sets `busy_o`. The engine then pulls bytes from the FIFO in pairs, waiting on the FIFO's data-available flag before each read. It writes each pair to the disk data register as one 16-bit word, and when the last word is done it pulses `done_o` and drops `busy_o`.

Only the first byte of each pair is stored. It sits in a high-byte register that drives the upper half of the disk bus. The second byte is not latched: it stays on the shared byte bus while the FIFO read strobe is held low, and the disk write strobe is pulsed inside that window. The read strobe opens one cycle before the write strobe falls and closes one cycle after it rises, which gives setup and hold margin on both halves of the bus.

A bypass mode serves transactions the engine does not handle, such as command setup and status reads. While the block is idle and `bypass_i` is high, every FIFO and disk control line follows the microcontroller's `sw_*` lines.

Top module: `sector_mover`

## Requirements
- R1: Asynchronous reset (`rst_ni` low) drives `fifo_rd_n_o`, `dsk_cs_n_o`, `dsk_rd_n_o` and `dsk_wr_n_o` high, and drives `busy_o` and `done_o` low.
- R2: A one-cycle high on `start_i`, sampled while idle with `bypass_i` low, starts a burst. `busy_o` is high from the next cycle until the burst ends.
- R3: A burst writes exactly WORDS (default 256) words. `done_o` is high for exactly one cycle, in the cycle after the last write strobe is released. `busy_o` is low in the cycle after that.
- R4: The FIFO read strobe `fifo_rd_n_o` (active low) falls only after a clock edge at which `fifo_avail_i` was high. While `fifo_avail_i` stays low, no further bytes are read.
- R5: Each written word is {first byte, second byte}. The first byte is on `dsk_data_o[15:8]` and the second byte, taken straight from `fifo_data_i`, is on `dsk_data_o[7:0]`. Word n of a burst uses FIFO bytes 2n and 2n+1.
- R6: `dsk_wr_n_o` is low for exactly WR_CYCLES (default 3, at least 2) consecutive cycles. `fifo_rd_n_o` is low during that pulse, in the cycle before it and in the cycle after it.
- R7: After each word there is at least one cycle in which `fifo_rd_n_o` and `dsk_wr_n_o` are both high, before the next read.
- R8: While `busy_o` is high, `dsk_cs_n_o` is low, `dsk_rd_n_o` is high and `dsk_addr_o` equals DATA_REG_ADDR (default 0).
- R9: A `start_i` pulse during a burst is ignored. The burst still writes exactly WORDS words, with one `done_o` pulse and no extra FIFO reads.
- R10: If `bypass_i` is high at an edge while idle, then from the next cycle `fifo_rd_n_o`, `dsk_addr_o`, `dsk_cs_n_o`, `dsk_rd_n_o` and `dsk_wr_n_o` follow the matching `sw_*` inputs. `start_i` is ignored in this mode. Dropping `bypass_i` returns all lines to their idle values (strobes and chip select high).
- R11: `bypass_i` raised during a burst has no effect on the disk lines until the burst ends. The control lines switch to the `sw_*` values only after the block has returned to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle burst request from the microcontroller |
| bypass_i | input | 1 | Requests manual control of all lines (honoured while idle) |
| busy_o | output | 1 | High while a burst is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a burst |
| fifo_avail_i | input | 1 | FIFO holds at least one byte |
| fifo_data_i | input | 8 | Shared byte bus from the FIFO |
| fifo_rd_n_o | output | 1 | FIFO read strobe, active low |
| dsk_data_o | output | 16 | Disk data bus: high-byte register and pass-through low byte |
| dsk_addr_o | output | 3 | Disk register address |
| dsk_cs_n_o | output | 1 | Disk chip select, active low |
| dsk_rd_n_o | output | 1 | Disk read strobe, active low |
| dsk_wr_n_o | output | 1 | Disk write strobe, active low |
| sw_fifo_rd_n_i | input | 1 | Manual FIFO read strobe used in bypass |
| sw_dsk_addr_i | input | 3 | Manual disk address used in bypass |
| sw_dsk_cs_n_i | input | 1 | Manual chip select used in bypass |
| sw_dsk_rd_n_i | input | 1 | Manual disk read strobe used in bypass |
| sw_dsk_wr_n_i | input | 1 | Manual disk write strobe used in bypass |

## Verification
The assertions assume that the FIFO keeps `fifo_data_i` stable for as long as `fifo_rd_n_o` is low, and changes it only after the strobe rises. They also assume that `fifo_avail_i` and `start_i` are clean, synchronous levels. The bench's FIFO model advances its read pointer only on a rising read strobe, and it changes every input half a cycle away from the active edge. The start-ignored and bypass-while-busy properties assume the microcontroller may assert those inputs at any time. The stimulus therefore deliberately raises them in the middle of a burst, including while the FIFO is stalled.

// File: rtl/sm_pkg.sv
package sm_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 3;

  typedef struct packed {
    logic              fifo_rd_n;
    logic              cs_n;
    logic              rd_n;
    logic              wr_n;
    logic [ADDR_W-1:0] addr;
  } ctl_t;

  typedef enum logic [3:0] {
    S_IDLE,
    S_WAIT_HI,
    S_RD_HI,
    S_WAIT_LO,
    S_LO_SETUP,
    S_LO_WR,
    S_LO_HOLD,
    S_GAP,
    S_BYP
  } state_e;
endpackage

// File: rtl/sm_word_ctr.sv
module sm_word_ctr #(
  parameter int unsigned WORDS = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int unsigned CW = (WORDS > 2) ? $clog2(WORDS) : 1;
  localparam logic [CW-1:0] LAST = CW'(WORDS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == LAST);

  // R3
  word_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |-> !last_o);
endmodule

// File: rtl/sm_pulse_timer.sv
module sm_pulse_timer #(
  parameter int unsigned CYCLES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int unsigned TW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
  localparam logic [TW-1:0] LOAD_VAL = TW'(CYCLES - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (load_i)               cnt_q <= LOAD_VAL;
    else if (run_i && !expired_o)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  // R6
  wr_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !expired_o) |=> run_i);
endmodule

// File: rtl/sm_ctrl_fsm.sv
module sm_ctrl_fsm
  import sm_pkg::*;
#(
  parameter logic [ADDR_W-1:0] DATA_REG_ADDR = '0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic bypass_i,
  input  logic avail_i,
  input  logic last_word_i,
  input  logic wr_expired_i,
  output ctl_t ctl_o,
  output logic byp_o,
  output logic busy_o,
  output logic done_o,
  output logic hi_load_o,
  output logic cnt_inc_o,
  output logic cnt_clr_o,
  output logic tmr_load_o,
  output logic tmr_run_o
);
  state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    state_d    = state_q;
    done_o     = 1'b0;
    hi_load_o  = 1'b0;
    cnt_inc_o  = 1'b0;
    cnt_clr_o  = 1'b0;
    tmr_load_o = 1'b0;
    tmr_run_o  = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        // bypass wins over start; start is dropped in that case
        if (bypass_i)     state_d = S_BYP;
        else if (start_i) state_d = S_WAIT_HI;
      end
      S_WAIT_HI: if (avail_i) state_d = S_RD_HI;
      S_RD_HI: begin
        hi_load_o = 1'b1;
        state_d   = S_WAIT_LO;
      end
      S_WAIT_LO: if (avail_i) state_d = S_LO_SETUP;
      S_LO_SETUP: begin
        tmr_load_o = 1'b1;
        state_d    = S_LO_WR;
      end
      S_LO_WR: begin
        tmr_run_o = 1'b1;
        if (wr_expired_i) state_d = S_LO_HOLD;
      end
      S_LO_HOLD: state_d = S_GAP;
      S_GAP: begin
        if (last_word_i) begin
          done_o    = 1'b1;
          cnt_clr_o = 1'b1;
          state_d   = S_IDLE;
        end else begin
          cnt_inc_o = 1'b1;
          state_d   = S_WAIT_HI;
        end
      end
      S_BYP: if (!bypass_i) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  logic rd_window;
  assign busy_o    = (state_q != S_IDLE) && (state_q != S_BYP);
  assign byp_o     = (state_q == S_BYP);
  assign rd_window = (state_q == S_RD_HI) || (state_q == S_LO_SETUP) ||
                     (state_q == S_LO_WR) || (state_q == S_LO_HOLD);

  always_comb begin
    ctl_o.fifo_rd_n = !rd_window;
    ctl_o.cs_n      = !busy_o;
    ctl_o.rd_n      = 1'b1;
    ctl_o.wr_n      = (state_q != S_LO_WR);
    ctl_o.addr      = DATA_REG_ADDR;
  end

  // R4
  rd_after_avail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $fell(ctl_o.fifo_rd_n)) |-> $past(avail_i));
  // R3
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!busy_o && !done_o));
  // R9
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_o && !done_o) |=> busy_o);
  // R11
  bypass_deferred_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> !byp_o);
endmodule

// File: rtl/sm_line_mux.sv
module sm_line_mux
  import sm_pkg::*;
(
  input  logic sel_sw_i,
  input  ctl_t eng_i,
  input  ctl_t sw_i,
  output ctl_t out_o
);
  assign out_o = sel_sw_i ? sw_i : eng_i;
endmodule

// File: rtl/sector_mover.sv
module sector_mover
  import sm_pkg::*;
#(
  parameter int unsigned       WORDS         = 256,
  parameter int unsigned       WR_CYCLES     = 3,
  parameter logic [ADDR_W-1:0] DATA_REG_ADDR = '0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                bypass_i,
  output logic                busy_o,
  output logic                done_o,
  input  logic                fifo_avail_i,
  input  logic [BYTE_W-1:0]   fifo_data_i,
  output logic                fifo_rd_n_o,
  output logic [2*BYTE_W-1:0] dsk_data_o,
  output logic [ADDR_W-1:0]   dsk_addr_o,
  output logic                dsk_cs_n_o,
  output logic                dsk_rd_n_o,
  output logic                dsk_wr_n_o,
  input  logic                sw_fifo_rd_n_i,
  input  logic [ADDR_W-1:0]   sw_dsk_addr_i,
  input  logic                sw_dsk_cs_n_i,
  input  logic                sw_dsk_rd_n_i,
  input  logic                sw_dsk_wr_n_i
);
  ctl_t eng_ctl, sw_ctl, out_ctl;
  logic byp, hi_load, cnt_inc, cnt_clr, last_word;
  logic tmr_load, tmr_run, tmr_expired;
  logic [BYTE_W-1:0] hi_q;

  sm_ctrl_fsm #(.DATA_REG_ADDR(DATA_REG_ADDR)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .bypass_i     (bypass_i),
    .avail_i      (fifo_avail_i),
    .last_word_i  (last_word),
    .wr_expired_i (tmr_expired),
    .ctl_o        (eng_ctl),
    .byp_o        (byp),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .hi_load_o    (hi_load),
    .cnt_inc_o    (cnt_inc),
    .cnt_clr_o    (cnt_clr),
    .tmr_load_o   (tmr_load),
    .tmr_run_o    (tmr_run)
  );

  sm_word_ctr #(.WORDS(WORDS)) u_words (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .inc_i  (cnt_inc),
    .last_o (last_word)
  );

  sm_pulse_timer #(.CYCLES(WR_CYCLES)) u_wr_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .run_i     (tmr_run),
    .expired_o (tmr_expired)
  );

  // only the first byte of a pair is stored; the second rides the shared bus
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hi_q <= '0;
    else if (hi_load) hi_q <= fifo_data_i;
  end

  always_comb begin
    sw_ctl.fifo_rd_n = sw_fifo_rd_n_i;
    sw_ctl.cs_n      = sw_dsk_cs_n_i;
    sw_ctl.rd_n      = sw_dsk_rd_n_i;
    sw_ctl.wr_n      = sw_dsk_wr_n_i;
    sw_ctl.addr      = sw_dsk_addr_i;
  end

  sm_line_mux u_mux (
    .sel_sw_i (byp),
    .eng_i    (eng_ctl),
    .sw_i     (sw_ctl),
    .out_o    (out_ctl)
  );

  assign fifo_rd_n_o = out_ctl.fifo_rd_n;
  assign dsk_cs_n_o  = out_ctl.cs_n;
  assign dsk_rd_n_o  = out_ctl.rd_n;
  assign dsk_wr_n_o  = out_ctl.wr_n;
  assign dsk_addr_o  = out_ctl.addr;
  assign dsk_data_o  = {hi_q, fifo_data_i};

  // R6
  wr_inside_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !dsk_wr_n_o) |-> !fifo_rd_n_o);
  // R6
  wr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $rose(dsk_wr_n_o)) |-> !fifo_rd_n_o);
  // R7
  word_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $rose(dsk_wr_n_o)) |=> (fifo_rd_n_o && dsk_wr_n_o));
  // R8
  burst_lines_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (!dsk_cs_n_o && dsk_rd_n_o && dsk_addr_o == DATA_REG_ADDR));
endmodule

// File: tb/sector_mover_bench.sv
module sector_mover_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS      = 256;
  localparam int WR_CYC     = 3;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, bypass_i = 1'b0;
  logic        busy_o, done_o;
  logic        fifo_avail_i;
  logic [7:0]  fifo_data_i;
  logic        fifo_rd_n_o;
  logic [15:0] dsk_data_o;
  logic [2:0]  dsk_addr_o;
  logic        dsk_cs_n_o, dsk_rd_n_o, dsk_wr_n_o;
  logic        sw_fifo_rd_n_i = 1'b1, sw_dsk_cs_n_i = 1'b1;
  logic        sw_dsk_rd_n_i = 1'b1, sw_dsk_wr_n_i = 1'b1;
  logic [2:0]  sw_dsk_addr_i = 3'd0;

  int n_chk = 0, n_bad = 0;
  int cyc = 0, ptr = 0, words = 0, done_cnt = 0, seen_id = 0;
  int burst_id = 0, fill = 1 << 20, stall_mode = 0;
  int wlen = 0;
  bit p_rd = 1'b1, p_wr = 1'b1, gap_due = 1'b0, av_edge = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] byte_at(int id, int k);
    return 8'((k * 29 + 7 + id * 13) & 255);
  endfunction

  assign fifo_data_i  = byte_at(burst_id, ptr);
  assign fifo_avail_i = (ptr < fill) && !(stall_mode != 0 && (cyc % 5 == 2 || cyc % 7 == 0));

  sector_mover u_sector_mover (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .bypass_i(bypass_i),
    .busy_o(busy_o), .done_o(done_o), .fifo_avail_i(fifo_avail_i),
    .fifo_data_i(fifo_data_i), .fifo_rd_n_o(fifo_rd_n_o), .dsk_data_o(dsk_data_o),
    .dsk_addr_o(dsk_addr_o), .dsk_cs_n_o(dsk_cs_n_o), .dsk_rd_n_o(dsk_rd_n_o),
    .dsk_wr_n_o(dsk_wr_n_o), .sw_fifo_rd_n_i(sw_fifo_rd_n_i),
    .sw_dsk_addr_i(sw_dsk_addr_i), .sw_dsk_cs_n_i(sw_dsk_cs_n_i),
    .sw_dsk_rd_n_i(sw_dsk_rd_n_i), .sw_dsk_wr_n_i(sw_dsk_wr_n_i)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) av_edge <= fifo_avail_i;

  // bus monitor
  always @(negedge clk) begin
    cyc++;
    if (seen_id != burst_id) begin
      seen_id = burst_id; ptr = 0; words = 0;
    end
    if (busy_o) begin
      chk(!dsk_cs_n_o && dsk_rd_n_o && dsk_addr_o == 3'd0, "R8 burst lines",
          {dsk_cs_n_o, dsk_rd_n_o, dsk_addr_o}, 32'h08);
      if (gap_due) begin
        chk(fifo_rd_n_o && dsk_wr_n_o, "R7 idle gap", {fifo_rd_n_o, dsk_wr_n_o}, 3);
        gap_due = 1'b0;
      end
      if (p_rd && !fifo_rd_n_o) chk(av_edge, "R4 read without data", av_edge, 1);
      if (!dsk_wr_n_o) begin
        if (p_wr) chk(!p_rd, "R6 setup", p_rd, 0);
        chk(!fifo_rd_n_o, "R6 rd low during wr", fifo_rd_n_o, 0);
        wlen++;
      end
      if (!p_wr && dsk_wr_n_o) begin
        chk(wlen == WR_CYC, "R6 wr width", wlen, WR_CYC);
        chk(!fifo_rd_n_o, "R6 hold", fifo_rd_n_o, 0);
        chk(dsk_data_o == {byte_at(burst_id, 2*words), byte_at(burst_id, 2*words+1)},
            "R5 word data", dsk_data_o,
            {byte_at(burst_id, 2*words), byte_at(burst_id, 2*words+1)});
        words++; wlen = 0; gap_due = 1'b1;
      end
      if (!p_rd && fifo_rd_n_o) ptr++;
      p_rd = fifo_rd_n_o; p_wr = dsk_wr_n_o;
    end else begin
      p_rd = 1'b1; p_wr = 1'b1; wlen = 0; gap_due = 1'b0;
    end
    if (done_o) done_cnt++;
    if (cyc > WATCHDOG) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic pulse_start();
    @(negedge clk); #1 start_i = 1'b1;
    @(negedge clk); #1 start_i = 1'b0;
  endtask

  task automatic wait_done(input int base, input string req);
    for (int i = 0; i < 8000 && done_cnt == base; i++) @(negedge clk);
    chk(done_cnt == base + 1, req, done_cnt - base, 1);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    chk(fifo_rd_n_o && dsk_cs_n_o && dsk_rd_n_o && dsk_wr_n_o, "R1 strobes in reset",
        {fifo_rd_n_o, dsk_cs_n_o, dsk_rd_n_o, dsk_wr_n_o}, 4'hf);
    chk(!busy_o && !done_o, "R1 status in reset", {busy_o, done_o}, 0);
    #1 rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy_o && dsk_wr_n_o && fifo_rd_n_o, "R1 idle after reset",
        {busy_o, dsk_wr_n_o, fifo_rd_n_o}, 3);
  endtask

  task automatic t_basic();
    int base;
    burst_id++; fill = 1 << 20; stall_mode = 0; base = done_cnt;
    @(negedge clk); #1 start_i = 1'b1;
    @(negedge clk);
    chk(busy_o, "R2 busy after start", busy_o, 1);
    #1 start_i = 1'b0;
    wait_done(base, "R3 one done pulse");
    chk(words == WORDS, "R3 word count", words, WORDS);
    chk(ptr == 2*WORDS, "R5 bytes consumed", ptr, 2*WORDS);
    @(negedge clk);
    chk(!busy_o && !done_o && dsk_cs_n_o, "R3 idle after done", {busy_o, done_o, dsk_cs_n_o}, 1);
    repeat (20) @(negedge clk);
    chk(done_cnt == base + 1 && !busy_o, "R2 no burst without start", done_cnt - base, 1);
  endtask

  task automatic t_stall();
    int base;
    burst_id++; fill = 100; stall_mode = 1; base = done_cnt;
    pulse_start();
    repeat (1500) @(negedge clk);
    chk(ptr == 100, "R4 reads stop at empty FIFO", ptr, 100);
    chk(words == 50 && busy_o, "R4 stalled burst waits", words, 50);
    @(negedge clk); #1 fill = 1 << 20;
    wait_done(base, "R4 stalled burst completes");
    chk(words == WORDS, "R3 word count with stalls", words, WORDS);
    @(negedge clk); #1 stall_mode = 0;
  endtask

  task automatic t_start_busy();
    int base;
    burst_id++; fill = 1 << 20; base = done_cnt;
    pulse_start();
    repeat (100) @(negedge clk);
    pulse_start();
    repeat (777) @(negedge clk);
    pulse_start();
    wait_done(base, "R9 single done");
    chk(words == WORDS && ptr == 2*WORDS, "R9 no restart", words, WORDS);
    repeat (30) @(negedge clk);
    chk(!busy_o && done_cnt == base + 1, "R9 stays idle", {busy_o, 8'(done_cnt - base)}, 1);
  endtask

  task automatic t_bypass();
    @(negedge clk); #1;
    bypass_i = 1'b1; sw_fifo_rd_n_i = 1'b0; sw_dsk_cs_n_i = 1'b0;
    sw_dsk_rd_n_i = 1'b0; sw_dsk_wr_n_i = 1'b1; sw_dsk_addr_i = 3'd5;
    @(negedge clk);
    chk({fifo_rd_n_o, dsk_cs_n_o, dsk_rd_n_o, dsk_wr_n_o, dsk_addr_o} == 7'b0001101,
        "R10 lines follow sw", {fifo_rd_n_o, dsk_cs_n_o, dsk_rd_n_o, dsk_wr_n_o, dsk_addr_o}, 7'b0001101);
    #1 sw_fifo_rd_n_i = 1'b1; sw_dsk_rd_n_i = 1'b1; sw_dsk_wr_n_i = 1'b0; sw_dsk_addr_i = 3'd2;
    @(negedge clk);
    chk({fifo_rd_n_o, dsk_cs_n_o, dsk_rd_n_o, dsk_wr_n_o, dsk_addr_o} == 7'b1010010,
        "R10 second pattern", {fifo_rd_n_o, dsk_cs_n_o, dsk_rd_n_o, dsk_wr_n_o, dsk_addr_o}, 7'b1010010);
    #1 start_i = 1'b1;
    @(negedge clk); #1 start_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy_o && !dsk_wr_n_o && dsk_addr_o == 3'd2, "R10 start ignored in bypass",
        {busy_o, dsk_wr_n_o}, 0);
    #1 bypass_i = 1'b0;
    sw_dsk_cs_n_i = 1'b1; sw_dsk_wr_n_i = 1'b1; sw_dsk_addr_i = 3'd0;
    @(negedge clk); #1 sw_dsk_cs_n_i = 1'b0; sw_dsk_wr_n_i = 1'b0;
    @(negedge clk);
    chk(fifo_rd_n_o && dsk_cs_n_o && dsk_rd_n_o && dsk_wr_n_o && !busy_o, "R10 exit to idle",
        {fifo_rd_n_o, dsk_cs_n_o, dsk_rd_n_o, dsk_wr_n_o}, 4'hf);
    #1 sw_dsk_cs_n_i = 1'b1; sw_dsk_wr_n_i = 1'b1;
  endtask

  task automatic t_bypass_busy();
    int base;
    burst_id++; fill = 1 << 20; base = done_cnt;
    pulse_start();
    repeat (40) @(negedge clk);
    #1 bypass_i = 1'b1; sw_fifo_rd_n_i = 1'b0; sw_dsk_cs_n_i = 1'b0;
    sw_dsk_wr_n_i = 1'b0; sw_dsk_addr_i = 3'd6;
    repeat (5) @(negedge clk);
    chk(busy_o && dsk_addr_o == 3'd0, "R11 bypass deferred", {busy_o, dsk_addr_o}, 8);
    wait_done(base, "R11 burst finishes under bypass request");
    chk(words == WORDS, "R11 word count", words, WORDS);
    @(negedge clk);
    chk(!busy_o, "R11 idle after done", busy_o, 0);
    @(negedge clk);
    chk(!dsk_wr_n_o && !fifo_rd_n_o && dsk_addr_o == 3'd6, "R11 bypass taken after burst",
        {dsk_wr_n_o, fifo_rd_n_o, dsk_addr_o}, 6);
    #1 bypass_i = 1'b0; sw_fifo_rd_n_i = 1'b1; sw_dsk_cs_n_i = 1'b1;
    sw_dsk_wr_n_i = 1'b1; sw_dsk_addr_i = 3'd0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_stall();
    t_start_busy();
    t_bypass();
    t_bypass_busy();
    t_basic();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule